// File: doc/BRIEF.md
# Serial Bus Format Auto-Switch Control Register

This block is an 8-bit control and status register for one channel of a two-wire serial bus. It chooses how the channel moves data. In formatless mode the channel shifts raw data. In I2C mode the channel uses the standard I2C framing. Software first arms the formatless mode by reading the register and then writing the mode bit to 1. When the auto-switch enable is set, the first falling edge seen on the serial clock line drops the channel back to I2C format without any help from software.

The same register holds three more things: an interrupt enable, a sticky flag that records a hardware auto-switch, and four write-only strobe bits. A write of 1 to a strobe bit sends a one-cycle pulse that clears one of the channel's internal latches. The CPU reaches the register over a plain synchronous select/read/write bus. The serial clock input passes through a synchronizer chain whose depth is set by a parameter before the falling edge is detected.

Top module: `fmt_switch_reg`

## Requirements
- R1: After reset, and in any cycle where `hw_stby` was high on the previous edge, the register reads 0x0F. `fmt_free` and `irq` are 0 and `latch_clr` is 0.
- R2: Bit 7 (auto-switch enable) and bit 5 (interrupt enable) store the value written and read it back.
- R3: Bit 6 (mode) reads back as stored and drives `fmt_free`. A value of 1 selects formatless transfer and 0 selects I2C format.
- R4: A write with bit 6 equal to 0 clears the mode bit on that clock edge.
- R5: A write with bit 6 equal to 1 sets the mode bit only if an earlier read returned bit 6 as 0 and no write has come since that read. Otherwise the write leaves the mode bit unchanged.
- R6: When the enable bit is 1, a falling edge on `scl` clears the mode bit exactly SYNC_STAGES+1 clock edges after `scl` goes low. When the enable bit is 0, the falling edge has no effect.
- R7: Bit 4 (flag) is set when a hardware auto-switch clears a mode bit that was 1. A write with bit 4 equal to 0 clears the flag. A write with bit 4 equal to 1 has no effect on it.
- R8: `irq` is 1 exactly when both the flag and the interrupt enable are 1.
- R9: A hardware flag set in the same cycle as a software write of 0 to the flag leaves the flag set. A hardware clear of the mode bit in the same cycle as a software write of 1 to the mode bit leaves the mode bit cleared.
- R10: Bits 3..0 always read as 1. A write puts write-data bits 3..0 on `latch_clr` for exactly the one cycle after the write edge. In every other cycle `latch_clr` is 0.
- R11: `reg_rdata` is 0 whenever the register is not being read (`reg_sel` and `reg_rd` are not both high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby; a synchronous return to the reset value |
| reg_sel | input | 1 | Register select |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| scl | input | 1 | Serial clock line, asynchronous |
| fmt_free | output | 1 | 1 = formatless transfer, 0 = I2C format |
| irq | output | 1 | Interrupt request |
| latch_clr | output | 4 | One-cycle latch-clear pulses |

## Verification
Two pairs of events can land on the same clock edge. In one pair, the detected falling edge of the serial clock arrives together with a CPU write that clears the flag. In the other pair, it arrives together with a write that tries to keep the mode bit at 1. The bench lowers `scl` and then places a write on exactly the edge where the synchronized fall takes effect. It sweeps the enable bit, the mode write bit and the flag write bit over every combination. After each collision it reads the register back and compares the result with a value computed from the priority rules.

// File: rtl/fmt_sw_pkg.sv
package fmt_sw_pkg;
   localparam int REG_W     = 8;
   localparam int BIT_EN    = 7;
   localparam int BIT_MODE  = 6;
   localparam int BIT_IE    = 5;
   localparam int BIT_FLAG  = 4;
   localparam int STROBE_N  = 4;
   localparam logic [REG_W-1:0] RESET_VAL = 8'h0F;
endpackage

// File: rtl/fmt_sw_sync.sv
module fmt_sw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic scl_i,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   chain[0] <= 1'b1;
               else if (clr) chain[0] <= 1'b1;
               else          chain[0] <= scl_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   chain[s] <= 1'b1;
               else if (clr) chain[s] <= 1'b1;
               else          chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_q <= 1'b1;
      else if (clr) last_q <= 1'b1;
      else          last_q <= chain[STAGES-1];
   end

   assign fall_o = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/fmt_sw_mode.sv
module fmt_sw_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic rd_hit,
   input  logic wr_hit,
   input  logic wr_en,
   input  logic wr_mode,
   input  logic fall,
   output logic en_o,
   output logic mode_o,
   output logic arm_o,
   output logic hw_clr_o
);
   logic en_q, mode_q, arm_q;
   logic auto_clr;

   assign auto_clr = fall & en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= 1'b0;
         arm_q  <= 1'b0;
      end else if (clr) begin
         en_q   <= 1'b0;
         mode_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (wr_hit) en_q <= wr_en;
         if (auto_clr)    mode_q <= 1'b0;
         else if (wr_hit) mode_q <= wr_mode & (mode_q | arm_q);
         if (wr_hit)                arm_q <= 1'b0;
         else if (rd_hit && !mode_q) arm_q <= 1'b1;
      end
   end

   assign en_o     = en_q;
   assign mode_o   = mode_q;
   assign arm_o    = arm_q;
   assign hw_clr_o = auto_clr & mode_q;
endmodule

// File: rtl/fmt_sw_strobe.sv
module fmt_sw_strobe #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         wr_hit,
   input  logic [N-1:0] wr_bits,
   output logic [N-1:0] pulse_o
);
   generate
      for (genvar b = 0; b < N; b++) begin : g_bit
         logic p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   p_q <= 1'b0;
            else if (clr) p_q <= 1'b0;
            else          p_q <= wr_hit & wr_bits[b];
         end
         assign pulse_o[b] = p_q;
      end
   endgenerate
endmodule

// File: rtl/fmt_switch_reg.sv
module fmt_switch_reg #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hw_stby,
   input  logic       reg_sel,
   input  logic       reg_rd,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       scl,
   output logic       fmt_free,
   output logic       irq,
   output logic [3:0] latch_clr
);
   import fmt_sw_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic rd_hit, wr_hit;
   logic fall_w, en_w, mode_w, arm_w, hw_clr_w;
   logic ie_q, flag_q;

   assign rd_hit = reg_sel & reg_rd;
   assign wr_hit = reg_sel & reg_wr;

   fmt_sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .clr(hw_stby), .scl_i(scl), .fall_o(fall_w)
   );

   fmt_sw_mode u_mode (
      .clk(clk), .rst_n(rst_n), .clr(hw_stby),
      .rd_hit(rd_hit), .wr_hit(wr_hit),
      .wr_en(reg_wdata[BIT_EN]), .wr_mode(reg_wdata[BIT_MODE]),
      .fall(fall_w), .en_o(en_w), .mode_o(mode_w), .arm_o(arm_w),
      .hw_clr_o(hw_clr_w)
   );

   fmt_sw_strobe #(.N(STROBE_N)) u_strobe (
      .clk(clk), .rst_n(rst_n), .clr(hw_stby), .wr_hit(wr_hit),
      .wr_bits(reg_wdata[STROBE_N-1:0]), .pulse_o(latch_clr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= RESET_VAL[BIT_IE];
         flag_q <= RESET_VAL[BIT_FLAG];
      end else if (hw_stby) begin
         ie_q   <= RESET_VAL[BIT_IE];
         flag_q <= RESET_VAL[BIT_FLAG];
      end else begin
         if (wr_hit) ie_q <= reg_wdata[BIT_IE];
         if (hw_clr_w)                          flag_q <= 1'b1;
         else if (wr_hit && !reg_wdata[BIT_FLAG]) flag_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (rd_hit) begin
         reg_rdata[BIT_EN]          = en_w;
         reg_rdata[BIT_MODE]        = mode_w;
         reg_rdata[BIT_IE]          = ie_q;
         reg_rdata[BIT_FLAG]        = flag_q;
         reg_rdata[STROBE_N-1:0]    = '1;
      end
   end

   assign fmt_free = mode_w;
   assign irq      = flag_q & ie_q;
endmodule

module fmt_switch_reg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       hw_stby,
   input logic       reg_sel,
   input logic       reg_rd,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic [7:0] reg_rdata,
   input logic       fmt_free,
   input logic [3:0] latch_clr,
   input logic       fall_w,
   input logic       en_w,
   input logic       arm_w,
   input logic       flag_q
);
   a_r6_auto_clear: assert property (@(posedge clk) disable iff (!rst_n || hw_stby)
      fall_w && en_w |=> !fmt_free);
   a_r5_set_needs_arm: assert property (@(posedge clk) disable iff (!rst_n || hw_stby)
      $rose(fmt_free) |-> $past(arm_w && reg_sel && reg_wr && reg_wdata[6]));
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n || hw_stby)
      flag_q && !(reg_sel && reg_wr && !reg_wdata[4]) |=> flag_q);
   a_r9_hw_flag_wins: assert property (@(posedge clk) disable iff (!rst_n || hw_stby)
      fall_w && en_w && fmt_free |=> flag_q);
   a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n || hw_stby)
      reg_sel && reg_wr |=> latch_clr == $past(reg_wdata[3:0]));
   a_r10_ones: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel && reg_rd |-> reg_rdata[3:0] == 4'hF);
   a_r3_mode_view: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel && reg_rd |-> reg_rdata[6] == fmt_free);
endmodule

bind fmt_switch_reg fmt_switch_reg_chk u_chk (
   .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .reg_sel(reg_sel),
   .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .fmt_free(fmt_free), .latch_clr(latch_clr),
   .fall_w(fall_w), .en_w(en_w), .arm_w(arm_w), .flag_q(flag_q)
);

// File: tb/fmt_switch_reg_bench.sv
module fmt_switch_reg_bench;
   localparam int SYNC = 2;
   logic clk = 1'b0, rst_n = 1'b0, hw_stby = 1'b0;
   logic reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0, scl = 1'b1;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic fmt_free, irq;
   logic [3:0] latch_clr;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   fmt_switch_reg #(.SYNC_STAGES(SYNC)) u_fmt_switch_reg (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .reg_sel(reg_sel),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .scl(scl), .fmt_free(fmt_free), .irq(irq),
      .latch_clr(latch_clr)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(output logic [7:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_sel = 1'b0; reg_rd = 1'b0;
   endtask

   task automatic scl_fall_settle();
      @(negedge clk); scl = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
      scl = 1'b1;
      repeat (SYNC + 2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r;
      logic prev_flag;
      repeat (3) @(negedge clk);
      // R11 / R1: idle read data and reset outputs
      chk("R11 idle rdata", reg_rdata, 8'h00);
      chk("R1 reset outputs", {fmt_free, irq, 2'b00, latch_clr}, 8'h00);
      rst_n = 1'b1;
      rd(r); chk("R1 reset value", r, 8'h0F);

      // R2 / R7: enable/IE sweep; writing 1 to the flag must not set it
      for (int v = 0; v < 4; v++) begin
         wr({v[1], 1'b0, v[0], 1'b1, 4'h0});
         rd(r); chk("R2 R7 bit store", r, {v[1], 1'b0, v[0], 1'b0, 4'hF});
      end

      // R10: strobe sweep
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = {4'h0, i[3:0]};
         @(negedge clk);
         reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
         chk("R10 pulse", {4'h0, latch_clr}, {4'h0, i[3:0]});
         @(negedge clk);
         chk("R10 pulse end", {4'h0, latch_clr}, 8'h00);
      end

      // R5: write 1 without an arming read is ignored
      wr(8'h40); rd(r); chk("R5 unarmed set", r, 8'h0F);
      // r is the arming read (bit6 = 0): now set
      wr(8'h40); chk("R3 fmt_free set", {7'h0, fmt_free}, 8'h01);
      rd(r); chk("R5 armed set", r, 8'h4F);
      // R4: write 0 clears
      wr(8'h00); chk("R4 clear", {7'h0, fmt_free}, 8'h00);
      // read while 0 arms, intervening write disarms
      rd(r); wr(8'h00); wr(8'h40);
      chk("R5 disarmed by write", {7'h0, fmt_free}, 8'h00);

      // R6: enable 0 -> fall has no effect
      rd(r); wr(8'h40);
      scl_fall_settle();
      chk("R6 no auto-switch when disabled", {7'h0, fmt_free}, 8'h01);
      // R6: enable 1 -> clear exactly SYNC+1 edges after scl falls
      wr(8'hE0);
      @(negedge clk); scl = 1'b0;
      repeat (SYNC) @(negedge clk);
      chk("R6 not yet", {7'h0, fmt_free}, 8'h01);
      @(negedge clk);
      chk("R6 auto-switch", {7'h0, fmt_free}, 8'h00);
      chk("R8 irq with IE", {7'h0, irq}, 8'h01);
      scl = 1'b1; repeat (SYNC + 2) @(negedge clk);
      rd(r); chk("R7 flag set", r, 8'hBF);
      wr(8'h90); chk("R8 irq masked", {7'h0, irq}, 8'h00);
      wr(8'h80); rd(r); chk("R7 flag cleared", r, 8'h8F);

      // R9: collision sweep over enable, write mode bit, write flag bit
      prev_flag = 1'b0;
      for (int c = 0; c < 8; c++) begin
         logic e, w6, w4, sw_e, fl_e;
         e = c[2]; w6 = c[1]; w4 = c[0];
         rd(r);
         wr({e, 1'b1, 1'b0, 1'b1, 4'h0});
         @(negedge clk); scl = 1'b0;
         repeat (SYNC - 1) @(negedge clk);
         @(negedge clk);
         reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = {e, w6, 1'b0, w4, 4'h0};
         @(negedge clk);
         reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
         sw_e = e ? 1'b0 : w6;
         fl_e = e ? 1'b1 : (w4 ? prev_flag : 1'b0);
         prev_flag = fl_e;
         scl = 1'b1; repeat (SYNC + 2) @(negedge clk);
         rd(r); chk("R9 collision", r, {e, sw_e, 1'b0, fl_e, 4'hF});
      end

      // R1: standby returns the reset value
      wr(8'hA0);
      @(negedge clk); hw_stby = 1'b1;
      @(negedge clk); hw_stby = 1'b0;
      rd(r); chk("R1 standby value", r, 8'h0F);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule